// File: doc/BRIEF.md
# Synchronous SRAM with selectable read latency

This block is a clocked static memory with a read path whose latency can be set. Commands are sampled on each rising clock edge. They come from three chip enables, an address, write data, per-byte write strobes, a byte-write enable and a global write enable. The address normally comes from a separate burst counter, so this block sees one address per cycle and can return one beat per cycle.

Read data goes through an array read register. A mode input then either adds a second output register (pipelined) or takes the output straight from the array register (flow-through). Output-enable state is tracked through the same stages as read data. A cycle that does not read therefore keeps the outputs on until its own slot reaches the output, so the drive turns off one full cycle later. The drive flag `dq_drive` shows when the data outputs would be enabled. An asynchronous output-enable pin and a sleep pin can force it off. Sleep also blocks new commands, and the memory keeps its contents while asleep.

Top module: `ssram_rdpipe`

## Requirements
- R1: A cycle is a selected command only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at the same time. Any other combination is a deselect, which neither writes nor drives.
- R2: With `pipe_mode`=1, a read sampled at edge k drives `dq_drive`=1 and presents the addressed word on `rdata` after edge k+2 (the third edge counting edge k).
- R3: With `pipe_mode`=0, a read sampled at edge k presents its word and `dq_drive`=1 after edge k+1 (the second edge counting edge k).
- R4: Reads on consecutive cycles return their words on consecutive cycles, one beat per cycle, with no gap.
- R5: A deselect sampled after a read keeps `dq_drive` high for one more cycle. The drive is released at the edge where that deselect's own slot reaches the output, in either mode.
- R6: With `gwe_n`=1 and `bwe_n`=0, a selected cycle writes only the bytes whose strobe `lane_wr_n[i]` is 0. Byte i is `wdata[9*i+8:9*i]`, and the other bytes keep their contents. A cycle with `bwe_n`=0 and no strobe low is a read.
- R7: With `gwe_n`=0, a selected cycle writes every byte, whatever `bwe_n` and `lane_wr_n` are.
- R8: A write cycle never drives the outputs in its slot.
- R9: `oe_n`=1 forces `dq_drive` low at once, without waiting for a clock edge, and leaves `rdata` unchanged.
- R10: While `sleep`=1, no command is accepted and `dq_drive` is low. Memory contents are kept and can be read after `sleep` returns to 0.
- R11: A read in the cycle right after a write to the same address returns the newly written data.
- R12: While `rst_n`=0, and for reads not yet issued after reset, `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline valid state |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | LANES*LANE_W (18) | Write data, byte i at bits 9*i+8:9*i |
| lane_wr_n | input | LANES (2) | Per-byte write strobes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| gwe_n | input | 1 | Global write enable, active low |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| rdata | output | LANES*LANE_W (18) | Read data |
| dq_drive | output | 1 | High when the data outputs are driven |

## Verification
The latency and deselect properties assume that `pipe_mode` stays constant between resets. They measure from the sampled command to a fixed output slot, so a mode change in flight would move the slot. The bench changes mode only while holding reset, then lets the pipeline run freely under random commands, enable patterns, output-enable toggles and sleep pulses. Random and directed addresses stay within a small window that is written first, so every read compares against a defined word and reads often hit recent writes.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // All three enables at their active level selects the device.
  function automatic logic chip_selected(input logic c1_n, input logic c2, input logic c3_n);
    return !c1_n && c2 && !c3_n;
  endfunction

endpackage

// File: rtl/ssram_cmd.sv
module ssram_cmd
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      sleep,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      bwe_n,
  input  logic                      gwe_n,
  output op_e                       op_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   wdata_q,
  output logic [LANES-1:0]          mask_q
);
  localparam int DATA_W = LANES * LANE_W;

  // Global write wins; byte write uses the strobes; otherwise nothing.
  function automatic logic [LANES-1:0] write_lanes(input logic gw_n, input logic bw_n,
                                                   input logic [LANES-1:0] strobe_n);
    if (!gw_n) return '1;
    if (!bw_n) return ~strobe_n;
    return '0;
  endfunction

  logic             accept;
  logic [LANES-1:0] lanes_now;
  op_e              op_next;

  assign accept    = chip_selected(ce1_n, ce2, ce3_n) && !sleep;
  assign lanes_now = write_lanes(gwe_n, bwe_n, lane_wr_n);

  always_comb begin
    if (!accept)        op_next = OP_IDLE;
    else if (|lanes_now) op_next = OP_WRITE;
    else                op_next = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_IDLE;
    else        op_q <= op_next;
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata[DATA_W-1:0];
    mask_q  <= lanes_now;
  end
endmodule

// File: rtl/ssram_array.sv
module ssram_array
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  op_e                       op_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES-1:0]          mask_i,
  output logic [LANES*LANE_W-1:0]   rd_data_q,
  output logic                      rd_vld_q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (op_i == OP_WRITE && mask_i[g])
        mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (op_i == OP_READ)
        lane_q <= mem[addr_i];
    end

    assign rd_data_q[g*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= (op_i == OP_READ);
  end
endmodule

// File: rtl/ssram_outpath.sv
module ssram_outpath #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic [DATA_W-1:0] s2_data,
  input  logic              s2_vld,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              drv_q,
  output logic              dq_drive
);
  logic [DATA_W-1:0] s3_data;
  logic              s3_vld;

  always_ff @(posedge clk) s3_data <= s2_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s3_vld <= 1'b0;
    else        s3_vld <= s2_vld;
  end

  // Mode picks the stage; drive state rides alongside the data.
  assign rdata    = pipe_mode ? s3_data : s2_data;
  assign drv_q    = pipe_mode ? s3_vld  : s2_vld;
  assign dq_drive = drv_q && !oe_n && !sleep;
endmodule

// File: rtl/ssram_rdpipe.sv
module ssram_rdpipe
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      bwe_n,
  input  logic                      gwe_n,
  input  logic                      pipe_mode,
  input  logic                      oe_n,
  input  logic                      sleep,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      dq_drive
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op_s1;
  logic [ADDR_W-1:0] addr_s1;
  logic [DATA_W-1:0] wdata_s1;
  logic [LANES-1:0]  mask_s1;
  logic [DATA_W-1:0] data_s2;
  logic              rd_s2;
  logic              drv_q;

  ssram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .sleep(sleep), .addr(addr), .wdata(wdata), .lane_wr_n(lane_wr_n),
    .bwe_n(bwe_n), .gwe_n(gwe_n), .op_q(op_s1), .addr_q(addr_s1),
    .wdata_q(wdata_s1), .mask_q(mask_s1)
  );

  ssram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .op_i(op_s1), .addr_i(addr_s1),
    .wdata_i(wdata_s1), .mask_i(mask_s1), .rd_data_q(data_s2), .rd_vld_q(rd_s2)
  );

  ssram_outpath #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .s2_data(data_s2),
    .s2_vld(rd_s2), .oe_n(oe_n), .sleep(sleep), .rdata(rdata),
    .drv_q(drv_q), .dq_drive(dq_drive)
  );
endmodule

// File: rtl/ssram_rdpipe_chk.sv
module ssram_rdpipe_chk
  import ssram_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             sleep,
  input logic             gwe_n,
  input logic             bwe_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             oe_n,
  input logic             pipe_mode,
  input op_e              op_s1,
  input logic [LANES-1:0] mask_s1,
  input logic             drv_q,
  input logic             dq_drive
);
  logic sel_ok, rd_cmd;
  assign sel_ok = !ce1_n && ce2 && !ce3_n && !sleep;
  assign rd_cmd = sel_ok && gwe_n && (bwe_n || &lane_wr_n);

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n || !ce2 || ce3_n) |=> op_s1 == OP_IDLE);

  p_pipe_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_cmd) |-> ##3 drv_q);

  p_flow_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_cmd) |-> ##2 drv_q);

  p_deselect_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !rd_cmd) |-> ##3 !drv_q);

  p_global_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !gwe_n) |=> (op_s1 == OP_WRITE) && (&mask_s1));

  p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive);

  p_sleep_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> op_s1 == OP_IDLE);

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |-> !dq_drive);
endmodule

bind ssram_rdpipe ssram_rdpipe_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .sleep(sleep), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_wr_n(lane_wr_n),
  .oe_n(oe_n), .pipe_mode(pipe_mode), .op_s1(op_s1), .mask_s1(mask_s1),
  .drv_q(drv_q), .dq_drive(dq_drive)
);

// File: tb/ssram_rdpipe_test.sv
`timescale 1ns/1ps
module ssram_rdpipe_test;
  localparam int AW = 8, LN = 2, LW = 9, DW = LN * LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, ce1_n, ce2, ce3_n, bwe_n, gwe_n, pipe_mode, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [LN-1:0] lane_wr_n;
  logic          dq_drive;

  ssram_rdpipe #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .addr(addr), .wdata(wdata), .lane_wr_n(lane_wr_n), .bwe_n(bwe_n),
    .gwe_n(gwe_n), .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .dq_drive(dq_drive)
  );

  int total = 0, bad = 0, n = 0;
  bit done = 0;
  logic [DW-1:0] model [16];
  bit            h_drv [4];
  logic [DW-1:0] h_dat [4];
  string         h_tag [4];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LN-1:0] lanes_of(input logic gw_n, input logic bw_n,
                                             input logic [LN-1:0] s_n);
    if (!gw_n) return '1;
    if (!bw_n) return ~s_n;
    return '0;
  endfunction

  // Inputs already set at a falling edge; model, clock, then check output slot.
  task automatic step(input string tag);
    bit sel = !ce1_n && ce2 && !ce3_n && !sleep;
    logic [LN-1:0] m = lanes_of(gwe_n, bwe_n, lane_wr_n);
    int slot = n % 4;
    h_tag[slot] = tag;
    h_dat[slot] = model[addr[3:0]];
    h_drv[slot] = sel && (m == '0);
    if (sel && m != '0)
      for (int i = 0; i < LN; i++)
        if (m[i]) model[addr[3:0]][i*LW +: LW] = wdata[i*LW +: LW];
    n++;
    @(posedge clk);
    @(negedge clk);
    begin
      int k = n - 1 - (pipe_mode ? 2 : 1);
      bit ed = (k >= 0) ? h_drv[k % 4] : 1'b0;
      string t = (k >= 0) ? h_tag[k % 4] : "R12";
      bit exp_drv = ed && !oe_n && !sleep;
      check(dq_drive === exp_drv, t, {17'b0, dq_drive}, {17'b0, exp_drv});
      if (ed) check(rdata === h_dat[k % 4], t, rdata, h_dat[k % 4]);
    end
  endtask

  task automatic sel_on(input logic [AW-1:0] a);
    ce1_n = 0; ce2 = 1; ce3_n = 0; addr = a;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    sel_on(a); gwe_n = 1; bwe_n = 1; lane_wr_n = '1; step(tag);
  endtask

  task automatic wr_g(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    sel_on(a); wdata = d; gwe_n = 0; bwe_n = 0; lane_wr_n = '1; step(tag);
  endtask

  task automatic wr_b(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [LN-1:0] s_n, input string tag);
    sel_on(a); wdata = d; gwe_n = 1; bwe_n = 0; lane_wr_n = s_n; step(tag);
  endtask

  task automatic idle(input string tag);
    ce1_n = 1; ce2 = 0; ce3_n = 1; gwe_n = 1; bwe_n = 1; lane_wr_n = '1; step(tag);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; pipe_mode = mode; oe_n = 0; sleep = 0;
    ce1_n = 1; ce2 = 0; ce3_n = 1; gwe_n = 1; bwe_n = 1; lane_wr_n = '1;
    addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    check(dq_drive === 1'b0, "R12", {17'b0, dq_drive}, '0);
    for (int i = 0; i < 4; i++) h_drv[i] = 0;
    n = 0;
    rst_n = 1;
  endtask

  task automatic directed();
    logic [DW-1:0] keep;
    for (int a = 0; a < 16; a++) wr_g(AW'(a), DW'(a * 32'h1111), "R7");
    wr_g(5, 18'h2_aaaa, "R7");
    wr_b(5, 18'h1_5555, 2'b10, "R6");
    rd(5, "R11");
    wr_b(6, 18'h3_ffff, 2'b11, "R6");
    rd(6, "R6");
    ce1_n = 0; ce2 = 0; ce3_n = 0; addr = 5; wdata = 18'h0; gwe_n = 0; step("R1");
    ce1_n = 0; ce2 = 1; ce3_n = 1; addr = 5; gwe_n = 1; bwe_n = 1; step("R1");
    rd(5, "R1");
    for (int a = 0; a < 4; a++) rd(AW'(a), "R4");
    idle("R5"); idle("R5");
    rd(7, "R5"); idle("R5"); wr_g(8, 18'h0_1234, "R8"); idle("R8"); idle("R8");
    rd(3, "R9"); idle("R9"); idle("R9");
    keep = rdata;
    oe_n = 1; #1;
    check(dq_drive === 1'b0, "R9", {17'b0, dq_drive}, '0);
    check(rdata === keep, "R9", rdata, keep);
    oe_n = 0; #1;
    sleep = 1; #1;
    check(dq_drive === 1'b0, "R10", {17'b0, dq_drive}, '0);
    wr_g(4, 18'h3_0f0f, "R10"); rd(4, "R10"); idle("R10");
    sleep = 0;
    rd(4, "R10"); idle("R10"); idle("R10");
  endtask

  task automatic random_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      logic [AW-1:0] a = AW'($urandom % 16);
      int r = $urandom % 10;
      oe_n  = ($urandom % 8) == 0;
      sleep = ($urandom % 16) == 0;
      if (r < 5)      rd(a, pipe_mode ? "R2" : "R3");
      else if (r < 7) wr_b(a, DW'($urandom), LN'($urandom), "R6");
      else if (r < 8) wr_g(a, DW'($urandom), "R7");
      else if (r < 9) idle("R5");
      else begin
        sel_on(a); gwe_n = 1; bwe_n = 1; lane_wr_n = '1;
        case ($urandom % 3)
          0: ce1_n = 1;
          1: ce2 = 0;
          default: ce3_n = 1;
        endcase
        step("R1");
      end
    end
    oe_n = 0; sleep = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1'b1);
    directed();
    random_run(600);
    do_reset(1'b0);
    directed();
    random_run(600);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule